// File: doc/BRIEF.md
# Configuration Item Register Port

This block is a bus slave that gives firmware read access to a small set of fixed configuration items. Software writes a 16-bit key to a selector register. The key chooses an item, and the write sets that item's read position back to zero. Each read of the data register then returns the next bytes of the item. Within one read, the lowest byte lane holds the lowest item byte.

The items are computed inside the block:

- A four-character signature.
- A feature bitmap that states whether an optional DMA path is present.
- A parameterised number of test items.

The block publishes the current key, read position and item length. It also accepts a position-advance request. A companion DMA engine uses these to share the same stream state as the register path.

The register layout is chosen by a parameter:

- **Port-mapped layout:** the selector is at address 0 and the data register is at address 1.
- **Memory-mapped layout:** the data register is at address 0 and the selector is at address 8.

Top module: `cfg_item_port`

## Requirements
- R1: After reset, cur_key is 0x0000, cur_off is 0, cur_len is 4 and bus_rvalid is low.
- R2: A write to the selector address loads cur_key from bus_wdata[15:0] and clears cur_off at the next clock edge. From that edge on, cur_len shows the new item's length. The selector address is 0 in the default port-mapped layout.
- R3: A read of the data address raises bus_rvalid one cycle after the request. Byte lane j (bits 8j+7:8j) holds item byte cur_off+j. cur_off then advances by DATA_BYTES (4 by default). The data address is 1 in the default layout.
- R4: Key 0x0000 is a 4-byte item whose bytes, in order, are 0x43 0x49 0x50 0x54.
- R5: Key 0x0001 is a 4-byte little-endian bitmap. Bit 0 is always 1 and bit 1 equals DMA_PRESENT (1 by default), so the bytes are 0x03 0x00 0x00 0x00.
- R6: Key 0x0002+k, for k below NUM_TEST (2 by default), has length TEST_LEN_BASE+k (6+k by default). Its byte i is 0x80 | k<<4 | i.
- R7: Bytes at or past the item length read as 0x00, and cur_off never exceeds cur_len. An unknown key has length 0 and reads all zeros.
- R8: When dma_adv is high, cur_off advances by dma_adv_len at the next edge, saturating at cur_len.
- R9: A data read and a DMA advance in the same cycle work as follows. The read uses the old offset. The new offset is old + DATA_BYTES + dma_adv_len, clamped to the length.
- R10: A selector write in the same cycle as a DMA advance wins, and cur_off becomes 0.
- R11: A write to the data address does not change cur_key or cur_off. A read of the selector address returns zero with bus_rvalid and does not change cur_off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8*DATA_BYTES | Write data; the selector uses bits 15:0 |
| bus_rdata | output | 8*DATA_BYTES | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| dma_adv | input | 1 | Offset-advance request from the DMA engine |
| dma_adv_len | input | OFF_W | Byte count to advance |
| cur_key | output | 16 | Selected item key |
| cur_off | output | OFF_W | Current read offset within the item |
| cur_len | output | OFF_W | Length of the selected item in bytes |

## Verification
The offset register has two writers: the register path and the DMA engine. Each can move it in the same cycle.

The bench provokes two collisions by driving dma_adv in the same cycle as a bus access:

- With a data read, the scoreboard expects the returned bytes from the old offset. The bench then checks that cur_off equals the clamped sum of both steps.
- With a selector write, the bench checks that the offset lands on zero rather than on the advance amount.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;
   localparam int KEY_W = 16;
   typedef logic [KEY_W-1:0] key_t;

   localparam key_t KEY_SIGNATURE = 16'h0000;
   localparam key_t KEY_FEATURES  = 16'h0001;
   localparam key_t KEY_TEST_BASE = 16'h0002;
   localparam int   FIXED_ITEM_LEN = 4;

   // decoded kind of bus access in the current cycle
   typedef enum logic [1:0] {
      ACC_IDLE    = 2'd0,
      ACC_SEL_WR  = 2'd1,
      ACC_DATA_RD = 2'd2,
      ACC_MISC_RD = 2'd3
   } acc_e;
endpackage

// File: rtl/cfg_item_decode.sv
module cfg_item_decode
   import cfg_item_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int MMIO_MAP = 0
) (
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output acc_e              acc
);
   logic [ADDR_W-1:0] sel_addr;
   logic [ADDR_W-1:0] data_addr;

   generate
      if (MMIO_MAP != 0) begin : g_mmio
         if (ADDR_W < 4) begin : g_bad_w
            $error("memory-mapped layout needs ADDR_W >= 4");
         end
         assign data_addr = '0;
         assign sel_addr  = ADDR_W'(8);
      end else begin : g_port
         if (ADDR_W < 1) begin : g_bad_w
            $error("port layout needs ADDR_W >= 1");
         end
         assign sel_addr  = '0;
         assign data_addr = ADDR_W'(1);
      end
   endgenerate

   always_comb begin
      acc = ACC_IDLE;
      if (req) begin
         if (wr) begin
            if (addr == sel_addr) acc = ACC_SEL_WR;
         end else if (addr == data_addr) begin
            acc = ACC_DATA_RD;
         end else begin
            acc = ACC_MISC_RD;
         end
      end
   end
endmodule

// File: rtl/cfg_item_rom.sv
module cfg_item_rom
   import cfg_item_pkg::*;
#(
   parameter int          DATA_BYTES    = 4,
   parameter int          OFF_W         = 16,
   parameter int          NUM_TEST      = 2,
   parameter int          TEST_LEN_BASE = 6,
   parameter int          DMA_PRESENT   = 1,
   parameter logic [31:0] SIGNATURE     = 32'h4349_5054
) (
   input  key_t                      key,
   input  logic [OFF_W-1:0]          off,
   output logic [OFF_W-1:0]          len,
   output logic [8*DATA_BYTES-1:0]   lanes
);
   localparam int IDX_W = OFF_W + 1;

   generate
      if (NUM_TEST > 8) begin : g_bad_num
         $error("NUM_TEST must be at most 8");
      end
      if (TEST_LEN_BASE + NUM_TEST - 1 > 16 || TEST_LEN_BASE < 1) begin : g_bad_len
         $error("test item lengths must lie in 1..16");
      end
   endgenerate

   function automatic logic is_test(key_t k);
      return (k >= KEY_TEST_BASE) && (k < KEY_TEST_BASE + key_t'(NUM_TEST));
   endfunction

   function automatic logic [OFF_W-1:0] len_of(key_t k);
      if (k == KEY_SIGNATURE || k == KEY_FEATURES) return OFF_W'(FIXED_ITEM_LEN);
      if (is_test(k)) return OFF_W'(TEST_LEN_BASE) + OFF_W'(k - KEY_TEST_BASE);
      return '0;
   endfunction

   function automatic logic [7:0] byte_of(key_t k, logic [IDX_W-1:0] idx);
      key_t t;
      t = k - KEY_TEST_BASE;
      if (idx >= {1'b0, len_of(k)}) return 8'h00;
      if (k == KEY_SIGNATURE) begin
         case (idx[1:0])
            2'd0:    return SIGNATURE[31:24];
            2'd1:    return SIGNATURE[23:16];
            2'd2:    return SIGNATURE[15:8];
            default: return SIGNATURE[7:0];
         endcase
      end
      if (k == KEY_FEATURES) begin
         if (idx == '0) return {6'b0, (DMA_PRESENT != 0), 1'b1};
         return 8'h00;
      end
      if (is_test(k)) return {1'b1, t[2:0], idx[3:0]};
      return 8'h00;
   endfunction

   assign len = len_of(key);

   for (genvar j = 0; j < DATA_BYTES; j++) begin : g_lane
      logic [IDX_W-1:0] idx;
      assign idx = {1'b0, off} + IDX_W'(j);
      assign lanes[8*j +: 8] = byte_of(key, idx);
   end
endmodule

// File: rtl/cfg_item_state.sv
module cfg_item_state
   import cfg_item_pkg::*;
#(
   parameter int DATA_BYTES = 4,
   parameter int OFF_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  acc_e             acc,
   input  key_t             wr_key,
   input  logic [OFF_W-1:0] len,
   input  logic             adv,
   input  logic [OFF_W-1:0] adv_len,
   output key_t             key,
   output logic [OFF_W-1:0] off
);
   localparam int SUM_W = OFF_W + 2;

   logic [SUM_W-1:0] step;
   logic [SUM_W-1:0] sum;
   logic [OFF_W-1:0] off_nxt;

   always_comb begin
      step = '0;
      if (acc == ACC_DATA_RD) step = step + SUM_W'(DATA_BYTES);
      if (adv)                step = step + {2'b00, adv_len};
      sum = {2'b00, off} + step;
      if (sum > {2'b00, len}) off_nxt = len;
      else                    off_nxt = sum[OFF_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key <= KEY_SIGNATURE;
         off <= '0;
      end else if (acc == ACC_SEL_WR) begin
         key <= wr_key;
         off <= '0;
      end else begin
         off <= off_nxt;
      end
   end
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
   import cfg_item_pkg::*;
#(
   parameter int          ADDR_W        = 4,
   parameter int          DATA_BYTES    = 4,
   parameter int          OFF_W         = 16,
   parameter int          MMIO_MAP      = 0,
   parameter int          DMA_PRESENT   = 1,
   parameter int          NUM_TEST      = 2,
   parameter int          TEST_LEN_BASE = 6,
   parameter logic [31:0] SIGNATURE     = 32'h4349_5054
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_req,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [8*DATA_BYTES-1:0] bus_wdata,
   output logic [8*DATA_BYTES-1:0] bus_rdata,
   output logic                    bus_rvalid,
   input  logic                    dma_adv,
   input  logic [OFF_W-1:0]        dma_adv_len,
   output logic [15:0]             cur_key,
   output logic [OFF_W-1:0]        cur_off,
   output logic [OFF_W-1:0]        cur_len
);
   localparam int DATA_W = 8 * DATA_BYTES;

   generate
      if (DATA_BYTES < 2 || DATA_BYTES > 8) begin : g_bad_bytes
         $error("DATA_BYTES must lie in 2..8 to carry the 16-bit key");
      end
      if (OFF_W < 5) begin : g_bad_off
         $error("OFF_W must be at least 5");
      end
   endgenerate

   acc_e              acc;
   key_t              key_q;
   logic [OFF_W-1:0]  off_q;
   logic [OFF_W-1:0]  len_w;
   logic [DATA_W-1:0] lanes_w;

   cfg_item_decode #(
      .ADDR_W  (ADDR_W),
      .MMIO_MAP(MMIO_MAP)
   ) u_dec (
      .req (bus_req),
      .wr  (bus_wr),
      .addr(bus_addr),
      .acc (acc)
   );

   cfg_item_rom #(
      .DATA_BYTES   (DATA_BYTES),
      .OFF_W        (OFF_W),
      .NUM_TEST     (NUM_TEST),
      .TEST_LEN_BASE(TEST_LEN_BASE),
      .DMA_PRESENT  (DMA_PRESENT),
      .SIGNATURE    (SIGNATURE)
   ) u_rom (
      .key  (key_q),
      .off  (off_q),
      .len  (len_w),
      .lanes(lanes_w)
   );

   cfg_item_state #(
      .DATA_BYTES(DATA_BYTES),
      .OFF_W     (OFF_W)
   ) u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .acc    (acc),
      .wr_key (bus_wdata[15:0]),
      .len    (len_w),
      .adv    (dma_adv),
      .adv_len(dma_adv_len),
      .key    (key_q),
      .off    (off_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= (acc == ACC_DATA_RD) || (acc == ACC_MISC_RD);
         if (acc == ACC_DATA_RD)      bus_rdata <= lanes_w;
         else if (acc == ACC_MISC_RD) bus_rdata <= '0;
      end
   end

   assign cur_key = key_q;
   assign cur_off = off_q;
   assign cur_len = len_w;
endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
   parameter int ADDR_W     = 4,
   parameter int DATA_BYTES = 4,
   parameter int OFF_W      = 16,
   parameter int MMIO_MAP   = 0
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_req,
   input logic                    bus_wr,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [8*DATA_BYTES-1:0] bus_wdata,
   input logic                    bus_rvalid,
   input logic                    dma_adv,
   input logic [15:0]             cur_key,
   input logic [OFF_W-1:0]        cur_off,
   input logic [OFF_W-1:0]        cur_len
);
   localparam logic [ADDR_W-1:0] SEL_A = (MMIO_MAP != 0) ? ADDR_W'(8) : ADDR_W'(0);

   logic sel_wr;
   assign sel_wr = bus_req && bus_wr && (bus_addr == SEL_A);

   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (cur_key == 16'h0000 && cur_off == '0));

   p_sel_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (cur_off == '0 && cur_key == $past(bus_wdata[15:0])));

   p_rvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr) |=> bus_rvalid);

   p_no_spurious_rvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_wr) |=> !bus_rvalid);

   p_off_in_item_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cur_off <= cur_len);

   p_adv_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_adv && !sel_wr) |=> (cur_off >= $past(cur_off)));

   p_sel_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr && dma_adv) |=> (cur_off == '0));

   p_ignored_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && !sel_wr && !dma_adv) |=> ($stable(cur_key) && $stable(cur_off)));
endmodule

bind cfg_item_port cfg_item_port_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_BYTES(DATA_BYTES),
   .OFF_W     (OFF_W),
   .MMIO_MAP  (MMIO_MAP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rvalid(bus_rvalid),
   .dma_adv   (dma_adv),
   .cur_key   (cur_key),
   .cur_off   (cur_off),
   .cur_len   (cur_len)
);

// File: tb/sim_cfg_item_port.sv
module sim_cfg_item_port;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DB = 4;
   localparam int OW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_req = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_rvalid;
   logic          dma_adv = 1'b0;
   logic [OW-1:0] dma_adv_len = '0;
   logic [15:0]   cur_key;
   logic [OW-1:0] cur_off;
   logic [OW-1:0] cur_len;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_item_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .dma_adv(dma_adv), .dma_adv_len(dma_adv_len),
      .cur_key(cur_key), .cur_off(cur_off), .cur_len(cur_len)
   );

   // item model from the requirements
   function automatic int m_len(logic [15:0] k);
      if (k == 16'h0000 || k == 16'h0001) return 4;
      if (k == 16'h0002) return 6;
      if (k == 16'h0003) return 7;
      return 0;
   endfunction

   function automatic logic [7:0] m_byte(logic [15:0] k, int i);
      logic [7:0] sig[4];
      sig = '{8'h43, 8'h49, 8'h50, 8'h54};
      if (i >= m_len(k)) return 8'h00;
      if (k == 16'h0000) return sig[i];
      if (k == 16'h0001) return (i == 0) ? 8'h03 : 8'h00;
      return 8'h80 | 8'((k - 16'h2) << 4) | 8'(i);
   endfunction

   function automatic logic [31:0] m_word(logic [15:0] k, int off);
      logic [31:0] w;
      for (int j = 0; j < DB; j++) w[8*j +: 8] = m_byte(k, off + j);
      return w;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pop expected read data as results appear
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            chk("R3 unexpected rvalid", 32'h1, 32'h0);
         end else begin
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic access(bit wr, logic [AW-1:0] a, logic [31:0] d, bit adv, int alen);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
      dma_adv = adv; dma_adv_len = OW'(alen);
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0; dma_adv = 1'b0;
   endtask

   task automatic sel(logic [15:0] k);
      access(1'b1, 4'd0, {16'h0, k}, 1'b0, 0);
      chk("R2 key", 32'(cur_key), 32'(k));
      chk("R2 off", 32'(cur_off), 32'h0);
      chk("R2 len", 32'(cur_len), 32'(m_len(k)));
   endtask

   task automatic rd(string tag, logic [31:0] exp, bit adv, int alen);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      access(1'b0, 4'd1, 32'h0, adv, alen);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 key", 32'(cur_key), 32'h0);
      chk("R1 off", 32'(cur_off), 32'h0);
      chk("R1 len", 32'(cur_len), 32'd4);
      chk("R1 rvalid", 32'(bus_rvalid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 signature, then R7 past end
      rd("R4 signature", 32'h5450_4943, 1'b0, 0);
      chk("R3 off advance", 32'(cur_off), 32'd4);
      rd("R7 past end sig", 32'h0, 1'b0, 0);
      chk("R7 off saturate", 32'(cur_off), 32'd4);

      // R5 feature bitmap
      sel(16'h0001);
      rd("R5 features", 32'h0000_0003, 1'b0, 0);

      // R6 test item 0, partial tail
      sel(16'h0002);
      rd("R6 item2 first", m_word(16'h2, 0), 1'b0, 0);
      rd("R6 R7 item2 tail", m_word(16'h2, 4), 1'b0, 0);
      chk("R6 tail bytes", m_word(16'h2, 4), 32'h0000_8584);
      chk("R7 off at len", 32'(cur_off), 32'd6);

      // R8 advance, R9 collision with read
      sel(16'h0003);
      access(1'b0, 4'd5, 32'h0, 1'b0, 0); // misc read clears nothing; rvalid expected
      exp_q.push_back(32'h0); tag_q.push_back("R11 misc read");
      access(1'b1, 4'd2, 32'h0, 1'b1, 2);
      chk("R8 advance", 32'(cur_off), 32'd2);
      rd("R9 read old off", m_word(16'h3, 2), 1'b1, 1);
      chk("R9 item3 bytes", m_word(16'h3, 2), 32'h9594_9392);
      chk("R9 combined off", 32'(cur_off), 32'd7);

      // R10 selector wins over advance
      access(1'b1, 4'd0, 32'h0000_0003, 1'b1, 3);
      chk("R10 sel wins", 32'(cur_off), 32'd0);
      access(1'b0, 4'd2, 32'h0, 1'b1, 100);
      exp_q.push_back(32'h0); tag_q.push_back("R11 misc read 2");
      chk("R8 saturate", 32'(cur_off), 32'd7);

      // R7 unknown key
      sel(16'h1234);
      rd("R7 unknown key", 32'h0, 1'b0, 0);
      chk("R7 unknown off", 32'(cur_off), 32'd0);

      // R11 ignored write and selector read
      sel(16'h0002);
      rd("R6 item2 again", m_word(16'h2, 0), 1'b0, 0);
      access(1'b1, 4'd1, 32'h0000_0001, 1'b0, 0);
      chk("R11 data write key", 32'(cur_key), 32'h2);
      chk("R11 data write off", 32'(cur_off), 32'd4);
      exp_q.push_back(32'h0); tag_q.push_back("R11 selector read");
      access(1'b0, 4'd0, 32'h0, 1'b0, 0);
      chk("R11 selector read off", 32'(cur_off), 32'd4);

      repeat (3) @(negedge clk);
      chk("R3 all reads returned", 32'(exp_q.size()), 32'h0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule